// File: doc/BRIEF.md
# Programmable Memory Cycle Pattern Sequencer

This block is a small microcoded engine that generates external memory cycles. Software fills an internal 64-word pattern store through a write port. Each control word drives the memory strobe lines for exactly one clock. Each word also carries a two-bit address-mux selector, an exception-enable flag, a repeat flag and an end-of-pattern flag. There are five request kinds: single read, burst read, single write, burst write and periodic timer expiry. Each kind starts execution at its own fixed offset in the store. From there the engine steps one word per clock until it reaches a word whose end flag is set.

Three external inputs are treated as exceptions: bus error, soft reset and hard reset. If the word executing when an exception arrives allows it, execution jumps to a dedicated exception pattern. Otherwise the exception is held pending and served once the current pattern ends. A per-kind loop count lets a word marked "repeat" branch back to the start of its pattern a programmed number of times.

The address lines can carry the raw access address, one of two right-shifted versions of it (upper bits moved onto the lower lines), or a separate memory-address-register value. A start-multiplex input picks the selection for the first clock of an access. In later clocks the selection comes from the mux field of the word one clock earlier.

Top module: `patseq_top`

## Requirements
- R1: A write on the load port (`ld_en_i` high at a clock edge) stores `ld_data_i` at `ld_addr_i`. The word layout is: strobes in bits [7:0], mux selector in [9:8], exception enable in [10], repeat in [11], end-of-pattern in [12]. A stored word is the one later executed from that address.
- R2: The `req_i` bits are [0] single read, [1] burst read, [2] single write, [3] burst write and [4] timer expiry. The start offsets are 0, 8, 24, 32 and 48 respectively, and the exception pattern starts at 60. A request seen while idle makes `busy_o` high on the next cycle, with `strobe_o` equal to the strobe field of the start word.
- R3: Requests not yet served stay pending. When idle, the engine grants the highest pending one in this order: exception, timer, single read, burst read, single write, burst write.
- R4: While busy, `strobe_o` shows the current word's strobes and the next word is the following address. A word with the end flag (and no loop taken or exception jump) ends the pattern. `busy_o` is then low for at least one cycle, during which `strobe_o` is 0.
- R5: The loop counter is loaded at the start of a pattern. Both read kinds load `rd_loop_i`, both write kinds load `wr_loop_i`, timer expiry loads `tmr_loop_i`, and the exception pattern loads 0. A repeat word with a non-zero counter branches to the pattern start and decrements the counter. With a zero counter, the repeat flag is ignored.
- R6: An exception during a busy cycle whose word has exception enable 1 makes the next executed word the one at offset 60. Execution then runs until an end-flagged word.
- R7: An exception during a busy cycle whose word has exception enable 0 does not alter that pattern. It is served as the exception pattern after the pattern ends.
- R8: Any one of `bus_err_i`, `soft_rst_i` or `hard_rst_i` counts as an exception.
- R9: In the first busy cycle of an access, `addr_o` is `addr_i >> sha_i` when `sam_i` was 1 at the grant, and `addr_i` otherwise.
- R10: In later busy cycles, `addr_o` follows the previous word's mux selector: 0 gives `addr_i`, 1 gives `addr_i >> sha_i`, 2 gives `addr_i >> shb_i`, and 3 gives `mar_i`. Vacated upper lines are 0.
- R11: While idle, `addr_o` equals `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Pattern store write enable |
| ld_addr_i | input | 6 | Pattern store write address |
| ld_data_i | input | 13 | Pattern store write data |
| req_i | input | 5 | Request pulses, one bit per kind |
| bus_err_i | input | 1 | Bus transfer error exception |
| soft_rst_i | input | 1 | Soft reset exception |
| hard_rst_i | input | 1 | Hard reset exception |
| rd_loop_i | input | 4 | Loop count for read kinds |
| wr_loop_i | input | 4 | Loop count for write kinds |
| tmr_loop_i | input | 4 | Loop count for timer expiry |
| sam_i | input | 1 | Multiplex address in first cycle |
| sha_i | input | 4 | Shift amount for selector 1 |
| shb_i | input | 4 | Shift amount for selector 2 |
| addr_i | input | 16 | Access address |
| mar_i | input | 16 | Memory address register value |
| busy_o | output | 1 | Pattern executing |
| strobe_o | output | 8 | Memory strobe lines |
| addr_o | output | 16 | Multiplexed address lines |

## Verification
The assertions assume that every input is known after reset and changes only away from the rising clock edge. They also assume that the exception inputs are sampled level signals, so one held high for several cycles counts once per cycle. The bench drives all inputs at the falling edge from a fixed-seed random source. It holds the load port quiet while a directed pattern runs, and it makes every random program contain end-flagged words often enough that patterns finish. The exception inputs are raised rarely, so random runs do not sit in the exception pattern.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

    // address multiplexer selector carried in each control word
    typedef enum logic [1:0] {
        AMX_RAW = 2'd0,
        AMX_A   = 2'd1,
        AMX_B   = 2'd2,
        AMX_MAR = 2'd3
    } amx_e;

    // pending-request slots, lowest index wins
    localparam int NREQ     = 6;
    localparam int SLOT_EXC = 0;
    localparam int SLOT_TMR = 1;
    localparam int SLOT_RD1 = 2;
    localparam int SLOT_RDB = 3;
    localparam int SLOT_WR1 = 4;
    localparam int SLOT_WRB = 5;

    // external request kinds
    localparam int REQ_KINDS = 5;

endpackage

// File: rtl/patseq_ram.sv
module patseq_ram #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 13,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/patseq_arb.sv
module patseq_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_top
            assign gnt_o[i] = req_i[i];
        end else begin : g_rest
            assign gnt_o[i] = req_i[i] & ~(|req_i[i-1:0]);
        end
    end
endmodule

// File: rtl/patseq_amux.sv
module patseq_amux
    import patseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SH_W   = 4
) (
    input  amx_e              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mar_i,
    input  logic [SH_W-1:0]   sha_i,
    input  logic [SH_W-1:0]   shb_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        unique case (sel_i)
            AMX_A:   addr_o = addr_i >> sha_i;
            AMX_B:   addr_o = addr_i >> shb_i;
            AMX_MAR: addr_o = mar_i;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/patseq_top.sv
module patseq_top
    import patseq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int STROBE_W  = 8,
    parameter int DEPTH     = 64,
    parameter int LOOP_W    = 4,
    parameter int SH_W      = 4,
    parameter int RD1_START = 0,
    parameter int RDB_START = 8,
    parameter int WR1_START = 24,
    parameter int WRB_START = 32,
    parameter int TMR_START = 48,
    parameter int EXC_START = 60,
    localparam int PC_W     = $clog2(DEPTH),
    localparam int WORD_W   = STROBE_W + 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 ld_en_i,
    input  logic [PC_W-1:0]      ld_addr_i,
    input  logic [WORD_W-1:0]    ld_data_i,
    input  logic [REQ_KINDS-1:0] req_i,
    input  logic                 bus_err_i,
    input  logic                 soft_rst_i,
    input  logic                 hard_rst_i,
    input  logic [LOOP_W-1:0]    rd_loop_i,
    input  logic [LOOP_W-1:0]    wr_loop_i,
    input  logic [LOOP_W-1:0]    tmr_loop_i,
    input  logic                 sam_i,
    input  logic [SH_W-1:0]      sha_i,
    input  logic [SH_W-1:0]      shb_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ADDR_W-1:0]    mar_i,
    output logic                 busy_o,
    output logic [STROBE_W-1:0]  strobe_o,
    output logic [ADDR_W-1:0]    addr_o
);
    localparam int AMX_LSB  = STROBE_W;
    localparam int EXEN_BIT = STROBE_W + 2;
    localparam int REP_BIT  = STROBE_W + 3;
    localparam int LAST_BIT = STROBE_W + 4;

    typedef struct packed {
        logic              busy;
        logic [PC_W-1:0]   pc;
        logic [PC_W-1:0]   base;
        logic [LOOP_W-1:0] cnt;
        logic [NREQ-1:0]   pend;
        amx_e              amx;
    } seq_t;

    seq_t st_d, st_q;

    logic [WORD_W-1:0] cur_word;
    logic              cur_exen, cur_rep, cur_last;
    amx_e              cur_amx;
    logic              exc_any, exc_take;
    logic [NREQ-1:0]   eff_req, arb_req, gnt;
    logic [PC_W-1:0]   pc_q, base_q;
    logic [LOOP_W-1:0] cnt_q;
    logic              exc_pend;

    patseq_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
        .clk_i   (clk_i),
        .we_i    (ld_en_i),
        .waddr_i (ld_addr_i),
        .wdata_i (ld_data_i),
        .raddr_i (st_q.pc),
        .rdata_o (cur_word)
    );

    assign cur_exen = cur_word[EXEN_BIT];
    assign cur_rep  = cur_word[REP_BIT];
    assign cur_last = cur_word[LAST_BIT];
    assign cur_amx  = amx_e'(cur_word[AMX_LSB+1:AMX_LSB]);

    assign exc_any  = bus_err_i | soft_rst_i | hard_rst_i;
    assign exc_take = st_q.busy & exc_any & cur_exen;
    assign eff_req  = st_q.pend | {req_i[3], req_i[2], req_i[1], req_i[0],
                                   req_i[4], exc_any & ~exc_take};
    assign arb_req  = st_q.busy ? '0 : eff_req;

    patseq_arb #(.N(NREQ)) u_arb (
        .req_i (arb_req),
        .gnt_o (gnt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = eff_req & ~gnt;
        st_d.amx  = AMX_RAW;
        if (!st_q.busy) begin
            if (|gnt) begin
                st_d.busy = 1'b1;
                st_d.amx  = sam_i ? AMX_A : AMX_RAW;
                st_d.cnt  = '0;
                st_d.pc   = PC_W'(EXC_START);
                if (gnt[SLOT_TMR]) begin
                    st_d.pc  = PC_W'(TMR_START);
                    st_d.cnt = tmr_loop_i;
                end else if (gnt[SLOT_RD1]) begin
                    st_d.pc  = PC_W'(RD1_START);
                    st_d.cnt = rd_loop_i;
                end else if (gnt[SLOT_RDB]) begin
                    st_d.pc  = PC_W'(RDB_START);
                    st_d.cnt = rd_loop_i;
                end else if (gnt[SLOT_WR1]) begin
                    st_d.pc  = PC_W'(WR1_START);
                    st_d.cnt = wr_loop_i;
                end else if (gnt[SLOT_WRB]) begin
                    st_d.pc  = PC_W'(WRB_START);
                    st_d.cnt = wr_loop_i;
                end
                st_d.base = st_d.pc;
            end
        end else if (exc_take) begin
            st_d.pc   = PC_W'(EXC_START);
            st_d.base = PC_W'(EXC_START);
            st_d.cnt  = '0;
            st_d.amx  = cur_amx;
        end else if (cur_rep && (st_q.cnt != '0)) begin
            st_d.pc  = st_q.base;
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.amx = cur_amx;
        end else if (cur_last) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.pc  = st_q.pc + 1'b1;
            st_d.amx = cur_amx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, pc: '0, base: '0, cnt: '0, pend: '0, amx: AMX_RAW};
        end else begin
            st_q <= st_d;
        end
    end

    patseq_amux #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_amux (
        .sel_i  (st_q.amx),
        .addr_i (addr_i),
        .mar_i  (mar_i),
        .sha_i  (sha_i),
        .shb_i  (shb_i),
        .addr_o (addr_o)
    );

    assign busy_o   = st_q.busy;
    assign strobe_o = st_q.busy ? cur_word[STROBE_W-1:0] : '0;

    assign pc_q     = st_q.pc;
    assign base_q   = st_q.base;
    assign cnt_q    = st_q.cnt;
    assign exc_pend = st_q.pend[SLOT_EXC];
endmodule

// File: rtl/patseq_chk.sv
module patseq_chk #(
    parameter int ADDR_W    = 16,
    parameter int PC_W      = 6,
    parameter int LOOP_W    = 4,
    parameter int NREQ      = 6,
    parameter int EXC_START = 60
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] addr_i,
    input logic              exc_any,
    input logic              cur_exen,
    input logic              cur_rep,
    input logic              cur_last,
    input logic [PC_W-1:0]   pc_q,
    input logic [PC_W-1:0]   base_q,
    input logic [LOOP_W-1:0] cnt_q,
    input logic              exc_pend,
    input logic [NREQ-1:0]   gnt
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt)); // R3

    AST_GRANT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && (|gnt)) |=> busy_o); // R2

    AST_STEP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(exc_any && cur_exen) && !cur_last && !(cur_rep && cnt_q != '0))
        |=> (busy_o && pc_q == $past(pc_q) + 1'b1)); // R4

    AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(exc_any && cur_exen) && cur_last && !(cur_rep && cnt_q != '0))
        |=> !busy_o); // R4

    AST_LOOP_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(exc_any && cur_exen) && cur_rep && cnt_q != '0)
        |=> (pc_q == $past(base_q) && cnt_q == $past(cnt_q) - 1'b1)); // R5

    AST_EXC_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && exc_any && cur_exen) |=> (busy_o && pc_q == PC_W'(EXC_START))); // R6

    AST_EXC_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && exc_any && !cur_exen) |=> exc_pend); // R7

    AST_IDLE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> addr_o == addr_i); // R11
endmodule

bind patseq_top patseq_chk #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .LOOP_W(LOOP_W), .NREQ(patseq_pkg::NREQ),
    .EXC_START(EXC_START)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .addr_o(addr_o),
    .addr_i(addr_i), .exc_any(exc_any), .cur_exen(cur_exen), .cur_rep(cur_rep),
    .cur_last(cur_last), .pc_q(pc_q), .base_q(base_q), .cnt_q(cnt_q),
    .exc_pend(exc_pend), .gnt(gnt)
);

// File: tb/patseq_top_test.sv
`timescale 1ns/1ps
module patseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [12:0] ld_data = '0;
    logic [4:0]  req = '0;
    logic        be = 1'b0, sr = 1'b0, hr = 1'b0;
    logic [3:0]  rd_loop = '0, wr_loop = '0, tmr_loop = '0;
    logic        sam = 1'b0;
    logic [3:0]  sha = 4'd4, shb = 4'd8;
    logic [15:0] addr = '0, mar = '0;
    logic        busy;
    logic [7:0]  strobe;
    logic [15:0] addr_out;

    int checks = 0;
    int fails = 0;
    string tag = "R4";

    // bench model of the engine, kept from the requirements
    logic [12:0] m_mem [64];
    logic        m_busy = 1'b0;
    logic [5:0]  m_pc = '0, m_base = '0;
    logic [3:0]  m_cnt = '0;
    logic [5:0]  m_pend = '0;
    logic [1:0]  m_amx = '0;

    always #2 clk = ~clk;

    patseq_top uut (
        .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
        .ld_data_i(ld_data), .req_i(req), .bus_err_i(be), .soft_rst_i(sr),
        .hard_rst_i(hr), .rd_loop_i(rd_loop), .wr_loop_i(wr_loop),
        .tmr_loop_i(tmr_loop), .sam_i(sam), .sha_i(sha), .shb_i(shb),
        .addr_i(addr), .mar_i(mar), .busy_o(busy), .strobe_o(strobe),
        .addr_o(addr_out)
    );

    function automatic logic [12:0] mkw(input logic [7:0] s, input logic [1:0] amx,
                                        input logic exen, input logic rep, input logic last);
        return {last, rep, exen, amx, s};
    endfunction

    function automatic logic [15:0] exp_addr(input logic [1:0] sel);
        case (sel)
            2'd1:    return addr >> sha;
            2'd2:    return addr >> shb;
            2'd3:    return mar;
            default: return addr;
        endcase
    endfunction

    task automatic model_update();
        logic [12:0] w;
        logic exc, take;
        logic [5:0] eff;
        int g;
        w    = m_mem[m_pc];
        exc  = be | sr | hr;                                   // R8
        take = m_busy & exc & w[10];
        eff  = m_pend | {req[3], req[2], req[1], req[0], req[4], exc & ~take};
        g    = -1;
        if (!m_busy) for (int i = 5; i >= 0; i--) if (eff[i]) g = i;   // R3
        if (g >= 0) eff[g] = 1'b0;
        m_pend = eff;
        if (!m_busy) begin
            m_amx = 2'd0;
            if (g >= 0) begin
                m_busy = 1'b1;
                m_amx  = sam ? 2'd1 : 2'd0;                    // R9
                case (g)
                    1: begin m_pc = 6'd48; m_cnt = tmr_loop; end
                    2: begin m_pc = 6'd0;  m_cnt = rd_loop;  end
                    3: begin m_pc = 6'd8;  m_cnt = rd_loop;  end
                    4: begin m_pc = 6'd24; m_cnt = wr_loop;  end
                    5: begin m_pc = 6'd32; m_cnt = wr_loop;  end
                    default: begin m_pc = 6'd60; m_cnt = 4'd0; end
                endcase
                m_base = m_pc;
            end
        end else if (take) begin                               // R6
            m_pc = 6'd60; m_base = 6'd60; m_cnt = 4'd0; m_amx = w[9:8];
        end else if (w[11] && m_cnt != 4'd0) begin             // R5
            m_pc = m_base; m_cnt = m_cnt - 4'd1; m_amx = w[9:8];
        end else if (w[12]) begin
            m_busy = 1'b0; m_amx = 2'd0;
        end else begin
            m_pc = m_pc + 6'd1; m_amx = w[9:8];                // R10
        end
        if (ld_en) m_mem[ld_addr] = ld_data;                   // R1
    endtask

    task automatic chk(input logic ok, input string what, input logic [15:0] act,
                       input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic compare();
        logic [7:0] es;
        logic [15:0] ea;
        es = m_busy ? m_mem[m_pc][7:0] : 8'h00;
        ea = m_busy ? exp_addr(m_amx) : addr;                  // R11
        chk(busy === m_busy, "busy", {15'd0, busy}, {15'd0, m_busy});
        chk(strobe === es, "strobe", {8'd0, strobe}, {8'd0, es});
        chk(addr_out === ea, "addr", addr_out, ea);
    endtask

    task automatic step();
        addr = 16'($urandom);
        mar  = 16'($urandom);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse(input logic [4:0] r);
        req = r; step(); req = '0;
    endtask

    task automatic wr(input int a, input logic [12:0] d);
        ld_en = 1'b1; ld_addr = 6'(a); ld_data = d; step(); ld_en = 1'b0;
    endtask

    task automatic load_prog();
        logic [12:0] w;
        for (int i = 0; i < 64; i++) begin
            w = mkw(8'(i) | 8'h40, 2'(i), 1'b0, 1'b0, 1'b0);
            if (i == 3 || i == 15 || i == 26 || i == 35 || i == 51 || i == 62 || i == 63) w[12] = 1'b1;
            if (i == 1 || i == 2 || i == 9 || i == 25 || i == 33 || i == 49 || i == 61) w[10] = 1'b1;
            if (i == 11 || i == 35 || i == 51) w[11] = 1'b1;
            wr(i, w);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        tag = "R4 R11 reset";
        compare();
        rst_n = 1'b1;

        tag = "R1 load and run";
        load_prog();
        pulse(5'b00001);
        idle(8);

        tag = "R2 each kind";
        for (int k = 0; k < 5; k++) begin
            pulse(5'(1 << k));
            idle(14);
        end

        tag = "R3 priority";
        pulse(5'b11111);
        idle(6);
        pulse(5'b00001);
        idle(60);

        tag = "R5 loops";
        rd_loop = 4'd2; wr_loop = 4'd1; tmr_loop = 4'd3;
        pulse(5'b00010); idle(30);
        pulse(5'b01000); idle(14);
        pulse(5'b10000); idle(20);
        rd_loop = 4'd0; pulse(5'b00010); idle(12);

        tag = "R6 exception taken";
        pulse(5'b00001); step();
        be = 1'b1; step(); be = 1'b0;
        idle(8);

        tag = "R8 soft reset";
        pulse(5'b00100); step();
        sr = 1'b1; step(); sr = 1'b0;
        idle(8);
        tag = "R8 hard reset";
        pulse(5'b01000); step();
        hr = 1'b1; step(); hr = 1'b0;
        idle(12);

        tag = "R7 exception deferred";
        pulse(5'b00001);
        be = 1'b1; step(); be = 1'b0;
        idle(14);

        tag = "R9 first cycle mux";
        sam = 1'b1; sha = 4'd5;
        pulse(5'b00100); idle(6);
        sam = 1'b0;
        pulse(5'b00100); idle(6);

        tag = "R10 word mux";
        shb = 4'd11;
        pulse(5'b00010); idle(12);

        tag = "R11 idle address";
        idle(10);

        tag = "R4 R10 random";
        for (int i = 0; i < 64; i++)
            wr(i, {($urandom % 4 == 0) ? 1'b1 : 1'b0, 12'($urandom)});
        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                rd_loop = 4'($urandom % 3); wr_loop = 4'($urandom % 3);
                tmr_loop = 4'($urandom % 3); sam = 1'($urandom);
                sha = 4'($urandom); shb = 4'($urandom);
            end
            req = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
            be  = ($urandom % 40 == 0);
            sr  = ($urandom % 60 == 0);
            hr  = ($urandom % 80 == 0);
            step();
        end
        req = '0; be = 1'b0; sr = 1'b0; hr = 1'b0;
        idle(40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule